// File: doc/BRIEF.md
# SPI Flash Status-Register Write Controller

This block is the slave-side command logic for a serial flash status register. It listens to a mode-0 SPI link (active-low select, clock, data in, data out), decodes three commands (write enable, status write, status read), and owns the 8-bit status register. That register holds a sticky write-lock bit, four block-protect bits, a write-enable latch and a busy flag. Neighbouring logic reads the live register value on `status_o`.

The serial link is oversampled by the system clock: edges of the serial clock are found by comparing it with its value one system clock earlier. A status write takes effect only when four conditions hold. A write-enable command must already have been accepted. The frame must end exactly after its second byte. The device must not be busy. The write-protect pin and the write-lock bit must not together form the hardware lock. An accepted write updates the register bits at once, when select rises, and then runs a self-timed busy period whose length in clock cycles is a parameter. When that period ends, the busy flag and the write-enable latch both clear.

Top module: `spi_sr_ctrl`

## Requirements
- R1: A status write (opcode 0x01) is executed only if the write-enable latch (bit 1) is already 1 when select rises. Otherwise the register is unchanged.
- R2: The write-enable command is opcode 0x06. The status-write frame is opcode 0x01 followed by one data byte. The status-read command is opcode 0x05. Bytes are sent MSB first, sampled on the rising serial clock edge.
- R3: A write-enable frame is accepted only if select rises after exactly 8 bits. A status write is accepted only if select rises after exactly 16 bits. Any other frame length changes nothing.
- R4: An executed status write copies data bits 7 and 5..2 into the register. Register bits 6, 1 and 0 are not taken from the data byte.
- R5: When the write-protect pin is low and bit 7 is 1, a status write is not executed: bits 7..2 keep their values and no busy period starts. In every other pin/bit combination, a status write with the latch set is executed.
- R6: An executed write sets bit 0 (busy) for exactly WR_CYCLES clock cycles, starting at the edge that sees select high. When the period ends, bits 0 and 1 both clear.
- R7: The status-read command drives the register MSB first on the falling serial clock edges. It repeats the full byte for as long as select stays low, including while the busy period runs.
- R8: While bit 0 is 1, write-enable and status-write commands are ignored.
- R9: Reset clears all eight register bits. The data output is low whenever select is high.
- R10: The write-enable command sets bit 1 in every combination of write-protect pin and bit 7, provided the device is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block; low while select is high |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Live status register value |

## Verification
The assertions check on every cycle that the busy flag follows the write-cycle counter. They also check that a busy period never begins without the latch set, that bits 7..2 stay frozen both under the hardware lock and while busy, that the counter steps down by one, and that the frame counters are clear while select is high. Only the bench scenarios can show the end-to-end results. Those include the exact busy length seen at the port, the serial read-back bytes (also during a write), the rejection of short and long frames, and the outcome of each write across the protect-pin and lock-bit combinations.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_WR_ENABLE = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_STATUS = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RD_STATUS = 8'h05;

    // register bit positions; read-back order depends on them
    localparam int SR_LOCK = 7;
    localparam int SR_BP_HI = 5;
    localparam int SR_BP_LO = 2;
    localparam int SR_WEL = 1;
    localparam int SR_BUSY = 0;

    typedef struct packed {
        logic              csn;
        logic              sck;
        logic [BIT_CW-1:0] bit_cnt;
        logic [1:0]        byte_cnt;
        logic [BYTE_W-2:0] shreg;
    } rx_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] data;
        logic              rd_act;
        logic [BIT_CW-1:0] out_cnt;
        logic [BYTE_W-1:0] tx;
        logic              miso;
    } ctl_state_t;

endpackage

// File: rtl/spi_sr_rx.sv
module spi_sr_rx
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              sck_fall_o,
    output logic              cs_rise_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic [1:0]        byte_idx_o,
    output logic [BIT_CW-1:0] bit_cnt_o,
    output logic [1:0]        byte_cnt_o
);

    rx_state_t state_d, state_q;
    logic      sck_rise;

    always_comb begin
        state_d    = state_q;
        state_d.csn = csn_i;
        state_d.sck = sck_i;
        sck_rise   = sck_i & ~state_q.sck & ~csn_i;
        sck_fall_o = ~sck_i & state_q.sck & ~csn_i;
        cs_rise_o  = csn_i & ~state_q.csn;
        byte_vld_o = 1'b0;
        rx_byte_o  = {state_q.shreg, mosi_i};
        byte_idx_o = state_q.byte_cnt;
        bit_cnt_o  = state_q.bit_cnt;
        byte_cnt_o = state_q.byte_cnt;
        if (csn_i) begin
            state_d.bit_cnt  = '0;
            state_d.byte_cnt = '0;
        end else if (sck_rise) begin
            state_d.shreg   = {state_q.shreg[BYTE_W-3:0], mosi_i};
            state_d.bit_cnt = state_q.bit_cnt + 1'b1;
            if (state_q.bit_cnt == BIT_CW'(BYTE_W - 1)) begin
                byte_vld_o = 1'b1;
                if (state_q.byte_cnt != 2'd3) begin
                    state_d.byte_cnt = state_q.byte_cnt + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{csn: 1'b1, sck: 1'b0, bit_cnt: '0, byte_cnt: '0, shreg: '0};
        end else begin
            state_q <= state_d;
        end
    end

    AST_FRAME_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.csn |-> (state_q.bit_cnt == '0 && state_q.byte_cnt == '0)); // R3

endmodule

// File: rtl/spi_sr_timer.sv
module spi_sr_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_o = (cnt_q != '0);
        done_o = (cnt_q == CW'(1));
        if (start_i) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TIMER_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (cnt_q == '0)); // R8

endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
    import spi_sr_pkg::*;
#(
    parameter int WR_CYCLES = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_csn,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic        wp_n,
    output logic [7:0]  status_o
);

    ctl_state_t        state_d, state_q;
    logic              sck_fall, cs_rise, byte_vld;
    logic [BYTE_W-1:0] rx_byte;
    logic [1:0]        byte_idx, byte_cnt;
    logic [BIT_CW-1:0] bit_cnt;
    logic              t_start, t_busy, t_done;
    logic              hw_lock, len_one, len_two;

    spi_sr_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_i      (spi_csn),
        .sck_i      (spi_sck),
        .mosi_i     (spi_mosi),
        .sck_fall_o (sck_fall),
        .cs_rise_o  (cs_rise),
        .byte_vld_o (byte_vld),
        .rx_byte_o  (rx_byte),
        .byte_idx_o (byte_idx),
        .bit_cnt_o  (bit_cnt),
        .byte_cnt_o (byte_cnt)
    );

    spi_sr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (t_start),
        .busy_o  (t_busy),
        .done_o  (t_done)
    );

    always_comb begin
        state_d = state_q;
        t_start = 1'b0;
        hw_lock = ~wp_n & state_q.sr[SR_LOCK];
        len_one = (bit_cnt == '0) && (byte_cnt == 2'd1);
        len_two = (bit_cnt == '0) && (byte_cnt == 2'd2);

        // command and data capture
        if (byte_vld) begin
            if (byte_idx == 2'd0) begin
                state_d.cmd = rx_byte;
                if (rx_byte == OP_RD_STATUS) begin
                    state_d.rd_act  = 1'b1;
                    state_d.out_cnt = '0;
                end
            end else if (byte_idx == 2'd1) begin
                state_d.data = rx_byte;
            end
        end

        // read-back shifter, driven on falling serial clock
        if (sck_fall && state_q.rd_act) begin
            if (state_q.out_cnt == '0) begin
                state_d.tx   = state_q.sr;
                state_d.miso = state_q.sr[BYTE_W-1];
            end else begin
                state_d.miso = state_q.tx[BIT_CW'(BYTE_W - 1) - state_q.out_cnt];
            end
            state_d.out_cnt = state_q.out_cnt + 1'b1;
        end

        if (spi_csn) begin
            state_d.rd_act  = 1'b0;
            state_d.miso    = 1'b0;
            state_d.out_cnt = '0;
        end

        // commit at select release
        if (cs_rise && !state_q.sr[SR_BUSY]) begin
            if (state_q.cmd == OP_WR_ENABLE && len_one) begin
                state_d.sr[SR_WEL] = 1'b1;
            end
            if (state_q.cmd == OP_WR_STATUS && len_two &&
                state_q.sr[SR_WEL] && !hw_lock) begin
                state_d.sr[SR_LOCK]            = state_q.data[SR_LOCK];
                state_d.sr[SR_BP_HI:SR_BP_LO]  = state_q.data[SR_BP_HI:SR_BP_LO];
                state_d.sr[SR_BUSY]            = 1'b1;
                t_start                        = 1'b1;
            end
        end

        if (t_done) begin
            state_d.sr[SR_BUSY] = 1'b0;
            state_d.sr[SR_WEL]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign spi_miso = state_q.miso & ~spi_csn;
    assign status_o = state_q.sr;

    AST_BUSY_TRACKS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.sr[SR_BUSY] == t_busy); // R6
    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.sr[SR_BUSY]) |-> state_q.sr[SR_WEL]); // R1
    AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && state_q.sr[SR_LOCK]) |=> $stable(state_q.sr[7:2])); // R5
    AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.sr[SR_BUSY] |=> $stable(state_q.sr[7:2])); // R8
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_csn) |=> !state_q.miso); // R9

endmodule

// File: tb/spi_sr_ctrl_tb.sv
`timescale 1ns/1ps
module spi_sr_ctrl_tb;

    localparam int WR_CYCLES = 400;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       wp_n = 1'b1;
    logic       spi_miso;
    logic [7:0] status_o;

    int n_run = 0;
    int n_fail = 0;
    int wip_cnt = 0;
    logic mon_en = 1'b0;
    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [7:0] mon_sh = '0;
    int         mon_n = 0;

    always #2.5 clk = ~clk;

    spi_sr_ctrl #(.WR_CYCLES(WR_CYCLES)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_csn  (spi_csn),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .wp_n     (wp_n),
        .status_o (status_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: assembles read-back bytes and compares with the scoreboard
    always @(posedge spi_sck) begin
        if (mon_en) begin
            mon_sh = {mon_sh[6:0], spi_miso};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected byte", {24'h0, mon_sh}, 32'hFFFF_FFFF);
                end else begin
                    chk(req_q.pop_front(), {24'h0, mon_sh}, {24'h0, exp_q.pop_front()});
                end
            end
        end
    end

    always @(negedge clk) begin
        if (status_o[0]) wip_cnt++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        spi_mosi = b;
        wait_clk(HALF);
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
    endtask

    task automatic spi_frame(input logic [31:0] bits, input int n);
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) send_bit(bits[31-i]);
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(6);
    endtask

    task automatic wren();
        spi_frame({8'h06, 24'h0}, 8);
    endtask

    task automatic wrsr(input logic [7:0] d);
        spi_frame({8'h01, d, 16'h0}, 16);
    endtask

    // driver: pushes expected bytes, then runs the read frame
    task automatic rdsr(input int nbytes, input logic [7:0] exp, input string req);
        for (int i = 0; i < nbytes; i++) begin
            exp_q.push_back(exp);
            req_q.push_back(req);
        end
        spi_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 8; i++) send_bit(i == 5 || i == 7);
        mon_en = 1'b1;
        for (int i = 0; i < nbytes * 8; i++) send_bit(1'b0);
        mon_en = 1'b0;
        wait_clk(HALF);
        spi_csn = 1'b1;
        wait_clk(6);
        chk({req, " queue drained"}, exp_q.size(), 0);
    endtask

    task automatic wait_idle();
        while (status_o[0]) @(negedge clk);
        wait_clk(2);
    endtask

    initial begin
        wait_clk(5);
        chk("R9 reset status", status_o, 8'h00);
        chk("R9 miso idle after reset", spi_miso, 1'b0);
        rst_n = 1'b1;
        wait_clk(3);

        wrsr(8'hFC);
        chk("R1 write without latch ignored", status_o, 8'h00);
        rdsr(1, 8'h00, "R1 read after ignored write");

        wren();
        chk("R2 R10 write enable sets latch", status_o, 8'h02);

        spi_frame({8'h01, 8'hFC, 16'h0}, 12);
        chk("R3 short frame rejected", status_o, 8'h02);
        spi_frame({8'h01, 8'hFC, 8'hFC, 8'h0}, 24);
        chk("R3 long frame rejected", status_o, 8'h02);

        wip_cnt = 0;
        wrsr(8'hFF);
        rdsr(2, 8'hBF, "R7 read during busy");
        wait_idle();
        chk("R4 only lock and protect bits written", status_o, 8'hBC);
        chk("R6 busy length", wip_cnt, WR_CYCLES);

        wp_n = 1'b0;
        wren();
        chk("R10 latch set under hardware lock", status_o, 8'hBE);
        wrsr(8'h00);
        wait_clk(20);
        chk("R5 hardware lock blocks write", status_o, 8'hBE);

        wp_n = 1'b1;
        wrsr(8'h00);
        wait_idle();
        chk("R5 pin high allows write", status_o, 8'h00);

        wren();
        wrsr(8'h3C);
        wrsr(8'h80);
        wren();
        chk("R8 busy write ignored mid-cycle", status_o, 8'h3F);
        wait_idle();
        chk("R8 busy commands ignored", status_o, 8'h3C);

        rdsr(3, 8'h3C, "R7 repeated read");
        chk("R9 miso low with select high", spi_miso, 1'b0);

        wp_n = 1'b0;
        wren();
        wrsr(8'h84);
        wait_idle();
        chk("R5 pin low lock clear allows write", status_o, 8'h84);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #750000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule